// File: doc/BRIEF.md
# Digital Dither Generator with Hold Extension

This block turns one channel's 10-bit average-current command into the set point that drives the current DAC. A triangular offset is superimposed on the command. Its size comes from a 5-bit amplitude code and its period from a 7-bit frequency code. The waveform advances on a timebase tick that the surrounding logic supplies. The result is limited so that the switch points stay inside a legal window, and a flag reports when that limit is active.

The offset steps through 4·Q positions per cycle. A cycle starts at the mean value while the waveform is rising. It climbs to +Q levels, falls to −Q levels, then climbs back to the mean. When the enhanced mode is on and the current comparator never reported a lower-threshold crossing during the falling segment, the waveform holds at its minimum. The hold lasts until a crossing arrives or a tick-counted timeout ends it. New amplitude and frequency codes are taken only at the start of a cycle. A disabled channel or a zero command produces no offset and returns the phase to the cycle start.

Top module: `dither_gen`

## Requirements
- R1: With the default Q=4, the offset level per position 0..15 is 0,1,2,3,4,3,2,1,0,−1,−2,−3,−4,−3,−2,−1. The offset equals level × amplitude code × LSB, with LSB=1 count. The position advances once every F ticks, where F is the frequency code and code 0 counts as 1. The output `dith_sp` equals setpoint + offset one clock after the position changes.
- R2: Amplitude code 0 gives no offset at any position.
- R3: The position wraps from 15 back to 0, so the period is 4·Q·F ticks.
- R4: The amplitude and frequency codes are sampled only while the phase sits at cycle start, meaning position 0 with no ticks yet counted toward the next step. Changes made at other times have no effect until the next cycle.
- R5: The enhanced mode uses `enh_en`=1. In this mode, if `low_cross` was not seen while the position lay in the falling segment (positions Q..3Q), the step that would leave position 3Q is replaced by a hold at level −Q.
- R6: A `low_cross` pulse during a hold ends the hold at the next clock and moves the position to 3Q+1, without needing a tick.
- R7: A hold with no crossing ends on its TMO-th tick, with TMO=15 by default, and the position then moves to 3Q+1.
- R8: A `low_cross` seen during the falling segment prevents the hold in that cycle.
- R9: The room above and below are computed as MAX_SW − hyst − setpoint and setpoint − hyst − MIN_SW, with defaults MIN_SW=25 and MAX_SW=1000. The offset magnitude is limited to the smaller of the two, with a floor of 0, so the same limit applies in both directions. `clip_flag` is 1 exactly when the limit reduced a nonzero offset.
- R10: When `chan_en`=0 or the setpoint is 0, the output equals the setpoint one clock later, `clip_flag` is 0, and the phase returns to cycle start.
- R11: While `rst_n` is low at a clock edge, `dith_sp` and `clip_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse, one clock wide |
| chan_en | input | 1 | Channel enable |
| setpoint | input | 10 | Average-current command |
| amp_code | input | 5 | Dither amplitude code |
| freq_code | input | 7 | Dither period code (ticks per step) |
| hyst_half | input | 6 | Half of the switching hysteresis band, in DAC counts |
| enh_en | input | 1 | Enables the hold at the minimum |
| low_cross | input | 1 | Lower switch threshold crossed, from the comparator |
| dith_sp | output | 10 | Dithered, limited set point |
| clip_flag | output | 1 | Offset was reduced by the window limit |

## Verification
A tick changes the position register at its own clock edge, and the output register follows one edge later, so results due to ticks are read two edges after the tick is raised. A crossing pulse that ends a hold follows the same two-edge path. A change to the setpoint, the enable or the hysteresis reaches the output after a single edge. The bench drives inputs and samples on falling clock edges and always waits these counts before comparing, so each expected value is read in the first cycle it is due.

// File: rtl/dith_pkg.sv
// Shared helpers for the dither generator.
// Assumes positions run 0 .. 4*q-1 and that a cycle begins at the mean while rising.
package dith_pkg;

    // Signed triangle level for a position: rises to +q, falls to -q, rises back to 0.
    function automatic int tri_level(input int pos, input int q);
        if (pos < q)
            return pos;
        else if (pos < 3 * q)
            return 2 * q - pos;
        else
            return pos - 4 * q;
    endfunction

endpackage

// File: rtl/dith_phase.sv
// Phase sequencer: divides ticks into waveform steps, walks the position
// through one cycle, applies the hold at the minimum in enhanced mode and
// latches the codes at cycle start.
// Assumes tick is a single-clock pulse and low_cross is already synchronous.
module dith_phase #(
    parameter int Q         = 4,
    parameter int AMP_W     = 5,
    parameter int FREQ_W    = 7,
    parameter int TMO_TICKS = 15,
    localparam int POS_N    = 4 * Q,
    localparam int POS_W    = $clog2(POS_N),
    localparam int TMO_W    = $clog2(TMO_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              low_cross,
    input  logic              enh_en,
    input  logic [AMP_W-1:0]  amp_in,
    input  logic [FREQ_W-1:0] freq_in,
    output logic [POS_W-1:0]  pos,
    output logic [AMP_W-1:0]  amp_q
);
    localparam logic [POS_W-1:0] FLOOR_P = POS_W'(3 * Q);
    localparam logic [POS_W-1:0] AFTER_P = POS_W'((3 * Q + 1) % POS_N);
    localparam logic [POS_W-1:0] LAST_P  = POS_W'(POS_N - 1);
    localparam logic [POS_W-1:0] TOP_P   = POS_W'(Q);
    localparam logic [TMO_W-1:0] TMO_END = TMO_W'(TMO_TICKS - 1);

    logic [FREQ_W-1:0] frq_q, div, eff_frq, div_last;
    logic [AMP_W-1:0]  eff_amp;
    logic [TMO_W-1:0]  tcnt;
    logic              hold, seen, at_start, falling, seen_now, step;

    // Select live or latched codes and decode the step condition.
    always_comb begin
        at_start = (pos == '0) && (div == '0) && !hold;
        eff_amp  = at_start ? amp_in  : amp_q;
        eff_frq  = at_start ? freq_in : frq_q;
        div_last = (eff_frq == '0) ? '0 : eff_frq - 1'b1;
        falling  = (pos >= TOP_P) && (pos <= FLOOR_P);
        seen_now = seen || (low_cross && falling);
        step     = tick && (div == div_last);
    end

    // Advance the divider, position, hold and timeout state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            div   <= '0;
            hold  <= 1'b0;
            seen  <= 1'b0;
            tcnt  <= '0;
            amp_q <= '0;
            frq_q <= '0;
        end else if (!active) begin
            pos   <= '0;
            div   <= '0;
            hold  <= 1'b0;
            seen  <= 1'b0;
            tcnt  <= '0;
            amp_q <= amp_in;
            frq_q <= freq_in;
        end else begin
            amp_q <= eff_amp;
            frq_q <= eff_frq;
            seen  <= (pos < TOP_P) ? 1'b0 : seen_now;
            if (hold) begin
                if (low_cross || (tick && tcnt == TMO_END)) begin
                    hold <= 1'b0;
                    pos  <= AFTER_P;
                    div  <= '0;
                    tcnt <= '0;
                end else if (tick) begin
                    tcnt <= tcnt + 1'b1;
                end
            end else if (tick) begin
                if (step) begin
                    div <= '0;
                    if (pos == FLOOR_P && enh_en && !seen_now) begin
                        hold <= 1'b1;
                        tcnt <= '0;
                    end else begin
                        pos <= (pos == LAST_P) ? '0 : pos + 1'b1;
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end

    // R5: a hold only ever sits at the waveform minimum.
    p_hold_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> pos == FLOOR_P);
    // R6: a crossing during a hold releases it at the next edge.
    p_cross_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hold && low_cross) |=> !hold && pos == AFTER_P);
    // R7: the hold tick count never passes the timeout.
    p_tmo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> tcnt <= TMO_END);
    // R1: without a tick or crossing the position does not move.
    p_pos_still_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !low_cross) |=> $stable(pos));
    // R4: codes stay latched away from cycle start.
    p_code_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && pos != '0) |=> $stable(amp_q) && $stable(frq_q));
    // R10: an inactive channel returns to cycle start.
    p_idle_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> pos == '0 && !hold);
endmodule

// File: rtl/dith_shape.sv
// Offset shaper: maps the position and latched amplitude code to a signed
// offset in DAC counts, spreading the amplitude evenly over the Q levels.
// Assumes OFF_W holds Q * max code * LSB plus a sign bit.
module dith_shape #(
    parameter int Q     = 4,
    parameter int AMP_W = 5,
    parameter int LSB   = 1,
    parameter int OFF_W = 8,
    localparam int POS_W = $clog2(4 * Q)
) (
    input  logic [POS_W-1:0]        pos,
    input  logic [AMP_W-1:0]        amp_q,
    output logic signed [OFF_W-1:0] offset
);
    import dith_pkg::*;

    // Level times amplitude step gives the current offset.
    always_comb begin
        offset = OFF_W'(tri_level(int'(pos), Q) * int'(amp_q) * LSB);
    end
endmodule

// File: rtl/dith_clip.sv
// Symmetric window limiter and output register: bounds the offset magnitude by
// the smaller headroom on either side of the setpoint and registers the result.
// Assumes MIN_SW <= MAX_SW < 2**SP_W.
module dith_clip #(
    parameter int SP_W   = 10,
    parameter int HYST_W = 6,
    parameter int OFF_W  = 8,
    parameter int MIN_SW = 25,
    parameter int MAX_SW = 1000,
    localparam int CW    = ((OFF_W > SP_W) ? OFF_W : SP_W) + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic [SP_W-1:0]         setpoint,
    input  logic [HYST_W-1:0]       hyst,
    input  logic signed [OFF_W-1:0] offset,
    output logic [SP_W-1:0]         dith_sp,
    output logic                    clip_flag
);
    logic signed [CW-1:0] sp_s, hy_s, off_s, up_room, dn_room, lim, mag, mag_c, off_c, sum;
    logic                 over;

    // Compute headroom, limit the magnitude and restore the sign.
    always_comb begin
        sp_s    = CW'(setpoint);
        hy_s    = CW'(hyst);
        off_s   = CW'(offset);
        up_room = CW'(MAX_SW) - hy_s - sp_s;
        dn_room = sp_s - hy_s - CW'(MIN_SW);
        lim     = (up_room < dn_room) ? up_room : dn_room;
        if (lim < 0)
            lim = '0;
        mag   = (off_s < 0) ? -off_s : off_s;
        over  = mag > lim;
        mag_c = over ? lim : mag;
        off_c = (off_s < 0) ? -mag_c : mag_c;
        sum   = sp_s + off_c;
    end

    // Register the limited set point and the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dith_sp   <= '0;
            clip_flag <= 1'b0;
        end else if (!active) begin
            dith_sp   <= setpoint;
            clip_flag <= 1'b0;
        end else begin
            dith_sp   <= sum[SP_W-1:0];
            clip_flag <= over;
        end
    end

    // R10: an inactive channel passes the setpoint through unflagged.
    p_idle_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !clip_flag && dith_sp == $past(setpoint));
endmodule

// File: rtl/dither_gen.sv
// Dither generator top: sequencer, shaper and window limiter for one channel.
// Assumes tick comes from a shared timebase and low_cross is synchronous to clk.
module dither_gen #(
    parameter int SP_W      = 10,
    parameter int AMP_W     = 5,
    parameter int FREQ_W    = 7,
    parameter int HYST_W    = 6,
    parameter int Q         = 4,
    parameter int LSB       = 1,
    parameter int TMO_TICKS = 15,
    parameter int MIN_SW    = 25,
    parameter int MAX_SW    = 1000,
    localparam int POS_W    = $clog2(4 * Q),
    localparam int OFF_W    = $clog2(Q * ((1 << AMP_W) - 1) * LSB + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              chan_en,
    input  logic [SP_W-1:0]   setpoint,
    input  logic [AMP_W-1:0]  amp_code,
    input  logic [FREQ_W-1:0] freq_code,
    input  logic [HYST_W-1:0] hyst_half,
    input  logic              enh_en,
    input  logic              low_cross,
    output logic [SP_W-1:0]   dith_sp,
    output logic              clip_flag
);
    logic                    active;
    logic [POS_W-1:0]        pos;
    logic [AMP_W-1:0]        amp_q;
    logic signed [OFF_W-1:0] offset;

    // Channel runs only when enabled with a nonzero command.
    always_comb active = chan_en && (setpoint != '0);

    dith_phase #(.Q(Q), .AMP_W(AMP_W), .FREQ_W(FREQ_W), .TMO_TICKS(TMO_TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(tick),
        .low_cross(low_cross), .enh_en(enh_en), .amp_in(amp_code),
        .freq_in(freq_code), .pos(pos), .amp_q(amp_q)
    );

    dith_shape #(.Q(Q), .AMP_W(AMP_W), .LSB(LSB), .OFF_W(OFF_W)) u_shape (
        .pos(pos), .amp_q(amp_q), .offset(offset)
    );

    dith_clip #(.SP_W(SP_W), .HYST_W(HYST_W), .OFF_W(OFF_W),
                .MIN_SW(MIN_SW), .MAX_SW(MAX_SW)) u_clip (
        .clk(clk), .rst_n(rst_n), .active(active), .setpoint(setpoint),
        .hyst(hyst_half), .offset(offset), .dith_sp(dith_sp), .clip_flag(clip_flag)
    );

    // R2: a zero amplitude code yields no offset.
    p_amp_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q == '0) |-> offset == '0);
    // R1: at cycle start position the offset is zero.
    p_mean_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> offset == '0);
endmodule

// File: tb/sim_dither_gen.sv
module sim_dither_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       chan_en = 1'b1;
    logic [9:0] setpoint = 10'd500;
    logic [4:0] amp_code = '0;
    logic [6:0] freq_code = 7'd1;
    logic [5:0] hyst_half = '0;
    logic       enh_en = 1'b0;
    logic       low_cross = 1'b0;
    logic [9:0] dith_sp;
    logic       clip_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dither_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
        .setpoint(setpoint), .amp_code(amp_code), .freq_code(freq_code),
        .hyst_half(hyst_half), .enh_en(enh_en), .low_cross(low_cross),
        .dith_sp(dith_sp), .clip_flag(clip_flag)
    );

    // Columns: setpoint, amp, freq, hyst, ticks, expected output, expected flag, requirement.
    localparam int NV = 13;
    localparam int VEC [NV][8] = '{
        '{500, 10, 1, 10,  2, 520, 0, 1},   // R1 rising
        '{500, 10, 1, 10,  4, 540, 0, 1},   // R1 peak
        '{500, 10, 1, 10, 12, 460, 0, 1},   // R1 trough
        '{500, 10, 3, 10,  7, 520, 0, 1},   // R1 divided steps
        '{500, 10, 2, 10,  9, 540, 0, 1},   // R1 divided peak
        '{500,  0, 1, 10,  4, 500, 0, 2},   // R2 zero amplitude
        '{500, 31, 1, 10,  4, 624, 0, 1},   // R1 full code
        '{950, 31, 1, 20,  4, 980, 1, 9},   // R9 top limited
        '{950, 31, 1, 20, 12, 920, 1, 9},   // R9 same limit below
        '{ 60,  8, 1, 10,  4,  85, 1, 9},   // R9 low side headroom
        '{ 30,  2, 1, 10,  4,  30, 1, 9},   // R9 no headroom
        '{500, 10, 1, 10, 16, 500, 0, 3},   // R3 wrap
        '{500, 10, 1, 10,  5, 530, 0, 1}    // R1 falling
    };

    task automatic check(input string req, input int exp_sp, input int exp_clip);
        total++;
        if (int'(dith_sp) != exp_sp || int'(clip_flag) != exp_clip) begin
            bad++;
            $display("FAIL %s: got sp=%0d clip=%0d expected sp=%0d clip=%0d",
                     req, dith_sp, clip_flag, exp_sp, exp_clip);
        end
    endtask

    task automatic setup(input int sp, input int amp, input int frq, input int hy, input bit enh);
        @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
        setpoint  = 10'(sp);
        amp_code  = 5'(amp);
        freq_code = 7'(frq);
        hyst_half = 6'(hy);
        enh_en    = enh;
        low_cross = 1'b0;
        chan_en   = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic pulse_cross();
        low_cross = 1'b1;
        @(negedge clk);
        low_cross = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got running expected finished");
        finish_run();
    end

    initial begin
        // R11: reset clears outputs.
        repeat (3) @(negedge clk);
        check("R11", 0, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0);
            ticks(VEC[v][4]);
            @(negedge clk);
            check($sformatf("R%0d", VEC[v][7]), VEC[v][5], VEC[v][6]);
        end

        // R4: codes changed mid-cycle wait for the next cycle.
        setup(500, 10, 1, 10, 1'b0);
        ticks(2);
        @(negedge clk);
        check("R4", 520, 0);
        amp_code  = 5'd20;
        freq_code = 7'd2;
        ticks(1);
        @(negedge clk);
        check("R4", 530, 0);
        ticks(13);
        @(negedge clk);
        check("R3", 500, 0);
        ticks(2);
        @(negedge clk);
        check("R4", 520, 0);

        // R10: disable passes the setpoint and resets the phase.
        chan_en = 1'b0;
        @(negedge clk);
        check("R10", 500, 0);
        chan_en = 1'b1;
        @(negedge clk);
        ticks(8);
        @(negedge clk);
        check("R10", 580, 0);
        setpoint = 10'd0;
        ticks(3);
        @(negedge clk);
        check("R10", 0, 0);

        // R5: plain mode leaves the floor, enhanced mode holds there.
        setup(500, 10, 1, 10, 1'b0);
        ticks(13);
        @(negedge clk);
        check("R5", 470, 0);
        setup(500, 10, 1, 10, 1'b1);
        ticks(13);
        @(negedge clk);
        check("R5", 460, 0);

        // R7: hold ends on the timeout tick.
        ticks(14);
        @(negedge clk);
        check("R7", 460, 0);
        ticks(1);
        @(negedge clk);
        check("R7", 470, 0);

        // R6: crossing releases the hold without a tick.
        setup(500, 10, 1, 10, 1'b1);
        ticks(16);
        @(negedge clk);
        check("R6", 460, 0);
        pulse_cross();
        @(negedge clk);
        check("R6", 470, 0);

        // R8: crossing on the falling slope prevents the hold.
        setup(500, 10, 1, 10, 1'b1);
        ticks(6);
        pulse_cross();
        ticks(7);
        @(negedge clk);
        check("R8", 470, 0);

        finish_run();
    end
endmodule